// File: doc/BRIEF.md
# Address Bus Request Controller

This block sits on the master side of a split-transaction processor bus and decides, cycle by cycle, whether the master asks for the address bus. It sees an internal level that says a transaction is queued, a cancel strobe, and a flag that says this master drove the address retry itself and owes a snoop copyback. It also samples the bus grant, address-busy and retry lines, which are all active low. It drives the active-low request line as a data and output-enable pair. It also pulses a one-cycle tenure-start indication when it sees a usable grant.

The request is registered, so every input sampled at a rising edge decides the request level for the following bus cycle. The address block gives notice one cycle ahead that it will launch a transfer start. This lets the request fall in the same cycle the start appears on the bus. A small counter follows how many address tenures are outstanding. It is for status only and never holds the request back. The request pin floats while hard reset is applied and while the checkstop input is high.

Top module: `addr_req_ctl`

## Requirements
- R1: Once reset has been released, if txn_pend_i is high at a rising edge and no condition from R2, R3, R4 or R6 holds, then br_n_o is low and br_oe_o is high after that edge.
- R2: The bus is parked and idle when bg_n_i is low and abb_n_i is high. If this is sampled at an edge, br_n_o is high after that edge. If bg_n_i is low while abb_n_i is low, the request is not suppressed.
- R3: ts_launch_i high at an edge means the transfer start is driven in the next cycle. In that cycle br_n_o is high, even if txn_pend_i stays high.
- R4: artry_n_i low at an edge, with snp_cpbk_i low, makes br_n_o high for the following cycle. If the work is still pending, the request returns on the cycle after that.
- R5: artry_n_i low at an edge with snp_cpbk_i high does not drop the request. br_n_o stays low when R1 otherwise applies.
- R6: cancel_i high at an edge makes br_n_o high after that edge and prevents a tenure start in that cycle.
- R7: start_tenure_o is high for exactly one cycle after an edge that samples a qualified grant. A qualified grant needs bg_n_i low, abb_n_i high, artry_n_i high, txn_pend_i high and cancel_i low. A grant held over further cycles gives no second pulse on the next cycle.
- R8: outstanding_o rises by one for each ts_launch_i and falls by one for each tenure_done_i. A cycle with both leaves it unchanged. It saturates at MAX_TENURES (default 5) and at 0, and its value never stops br_n_o from going low.
- R9: While rst_n is low, br_oe_o is low and br_n_o is high. checkstop_i high at an edge makes br_oe_o low and br_n_o high after that edge. The output is driven again one cycle after checkstop_i falls.
- R10: Reset is asynchronous on assertion and released on the second rising edge after rst_n rises. In the first cycle after release, br_n_o is high, br_oe_o is high, start_tenure_o is low and outstanding_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous assert |
| checkstop_i | input | 1 | Checkstop condition; floats the request pin |
| txn_pend_i | input | 1 | Internal transaction queued |
| cancel_i | input | 1 | Internal request cancelled |
| snp_cpbk_i | input | 1 | This master drove the retry and owes a copyback |
| bg_n_i | input | 1 | Bus grant, active low |
| abb_n_i | input | 1 | Address bus busy, active low |
| artry_n_i | input | 1 | Address retry, active low |
| ts_launch_i | input | 1 | Transfer start will be driven next cycle |
| tenure_done_i | input | 1 | One address tenure completed |
| br_n_o | output | 1 | Bus request, active low |
| br_oe_o | output | 1 | Output enable for the request pin |
| start_tenure_o | output | 1 | One-cycle pulse on a qualified grant |
| outstanding_o | output | CNT_W | Outstanding address tenure count |

## Verification
A wrong drop decision shows up on br_n_o in the very next cycle, because every input condition maps to the request level one edge later. A start pulse that misses its edge guard shows up as a repeated start_tenure_o while a grant is held. A counter that misses saturation shows up on outstanding_o within one increment past the limit or one decrement below zero. A fault in the output-enable path shows up at once, during reset or one cycle after checkstop.

// File: rtl/addr_req_pkg.sv
package addr_req_pkg;

  // Why the request is in its current state; the first matching cause wins
  typedef enum logic [2:0] {
    BR_NO_WORK   = 3'd0,
    BR_LAUNCH    = 3'd1,
    BR_RETRY     = 3'd2,
    BR_PARKED    = 3'd3,
    BR_REQUEST   = 3'd4
  } br_cause_e;

endpackage

// File: rtl/addr_req_rst_sync.sv
module addr_req_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_q_n = sync_q[STAGES-1];

endmodule

// File: rtl/addr_req_decide.sv
module addr_req_decide
  import addr_req_pkg::*;
(
  input  logic clk,
  input  logic rst_q_n,
  input  logic txn_pend_i,
  input  logic cancel_i,
  input  logic snp_cpbk_i,
  input  logic bg_n_i,
  input  logic abb_n_i,
  input  logic artry_n_i,
  input  logic ts_launch_i,
  output logic req_o,
  output logic start_o
);

  br_cause_e cause_d;
  logic      req_d;
  logic      req_q;
  logic      start_d;
  logic      start_q;
  logic      parked_idle;
  logic      retry_drop;
  logic      work;

  always_comb begin
    work        = txn_pend_i && !cancel_i;
    parked_idle = !bg_n_i && abb_n_i;
    retry_drop  = !artry_n_i && !snp_cpbk_i;

    if (!work) begin
      cause_d = BR_NO_WORK;
    end else if (ts_launch_i) begin
      cause_d = BR_LAUNCH;
    end else if (retry_drop) begin
      cause_d = BR_RETRY;
    end else if (parked_idle) begin
      cause_d = BR_PARKED;
    end else begin
      cause_d = BR_REQUEST;
    end

    req_d   = (cause_d == BR_REQUEST);
    start_d = work && parked_idle && artry_n_i && !start_q;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      req_q   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      req_q   <= req_d;
      start_q <= start_d;
    end
  end

  assign req_o   = req_q;
  assign start_o = start_q;

endmodule

// File: rtl/addr_req_tenure_cnt.sv
module addr_req_tenure_cnt #(
  parameter int unsigned MAX_TENURES = 5,
  parameter int unsigned CNT_W       = $clog2(MAX_TENURES + 1)
) (
  input  logic             clk,
  input  logic             rst_q_n,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_TENURES);

  logic [CNT_W-1:0] count_d;
  logic [CNT_W-1:0] count_q;
  logic             cnt_en;

  always_comb begin
    count_d = count_q;
    cnt_en  = inc_i ^ dec_i;
    if (inc_i && !dec_i && (count_q != CNT_MAX)) begin
      count_d = count_q + 1'b1;
    end else if (dec_i && !inc_i && (count_q != '0)) begin
      count_d = count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      count_q <= '0;
    end else if (cnt_en) begin
      count_q <= count_d;
    end
  end

  assign count_o = count_q;

endmodule

// File: rtl/addr_req_ctl.sv
module addr_req_ctl #(
  parameter int unsigned MAX_TENURES = 5,
  parameter int unsigned CNT_W       = $clog2(MAX_TENURES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             checkstop_i,
  input  logic             txn_pend_i,
  input  logic             cancel_i,
  input  logic             snp_cpbk_i,
  input  logic             bg_n_i,
  input  logic             abb_n_i,
  input  logic             artry_n_i,
  input  logic             ts_launch_i,
  input  logic             tenure_done_i,
  output logic             br_n_o,
  output logic             br_oe_o,
  output logic             start_tenure_o,
  output logic [CNT_W-1:0] outstanding_o
);

  logic rst_q_n;
  logic req;
  logic oe_d;
  logic oe_q;

  addr_req_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  addr_req_decide u_decide (
    .clk         (clk),
    .rst_q_n     (rst_q_n),
    .txn_pend_i  (txn_pend_i),
    .cancel_i    (cancel_i),
    .snp_cpbk_i  (snp_cpbk_i),
    .bg_n_i      (bg_n_i),
    .abb_n_i     (abb_n_i),
    .artry_n_i   (artry_n_i),
    .ts_launch_i (ts_launch_i),
    .req_o       (req),
    .start_o     (start_tenure_o)
  );

  addr_req_tenure_cnt #(
    .MAX_TENURES (MAX_TENURES),
    .CNT_W       (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_q_n (rst_q_n),
    .inc_i   (ts_launch_i),
    .dec_i   (tenure_done_i),
    .count_o (outstanding_o)
  );

  always_comb begin
    oe_d = !checkstop_i;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      oe_q <= 1'b0;
    end else begin
      oe_q <= oe_d;
    end
  end

  assign br_oe_o = oe_q;
  assign br_n_o  = !(req && oe_q);

endmodule

// File: rtl/addr_req_ctl_chk.sv
module addr_req_ctl_chk #(
  parameter int unsigned MAX_TENURES = 5,
  parameter int unsigned CNT_W       = $clog2(MAX_TENURES + 1)
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             checkstop_i,
  input logic             txn_pend_i,
  input logic             cancel_i,
  input logic             snp_cpbk_i,
  input logic             bg_n_i,
  input logic             abb_n_i,
  input logic             artry_n_i,
  input logic             ts_launch_i,
  input logic             br_n_o,
  input logic             br_oe_o,
  input logic             start_tenure_o,
  input logic [CNT_W-1:0] outstanding_o
);

  // R2
  park_drop_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!bg_n_i && abb_n_i) |=> br_n_o);

  // R3
  launch_drop_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    ts_launch_i |=> br_n_o);

  // R4
  retry_drop_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!artry_n_i && !snp_cpbk_i) |=> br_n_o);

  // R5
  copyback_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!artry_n_i && snp_cpbk_i && txn_pend_i && !cancel_i && !ts_launch_i &&
     !(!bg_n_i && abb_n_i) && !checkstop_i) |=> !br_n_o);

  // R6
  cancel_drop_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    cancel_i |=> (br_n_o && !start_tenure_o));

  // R7
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    start_tenure_o |=> !start_tenure_o);

  // R7
  start_qual_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !(!bg_n_i && abb_n_i && artry_n_i && txn_pend_i && !cancel_i) |=> !start_tenure_o);

  // R8
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    outstanding_o <= CNT_W'(MAX_TENURES));

  // R9
  checkstop_float_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    checkstop_i |=> (!br_oe_o && br_n_o));

endmodule

bind addr_req_ctl addr_req_ctl_chk #(
  .MAX_TENURES (MAX_TENURES),
  .CNT_W       (CNT_W)
) u_chk (
  .clk            (clk),
  .rst_ok         (rst_q_n),
  .checkstop_i    (checkstop_i),
  .txn_pend_i     (txn_pend_i),
  .cancel_i       (cancel_i),
  .snp_cpbk_i     (snp_cpbk_i),
  .bg_n_i         (bg_n_i),
  .abb_n_i        (abb_n_i),
  .artry_n_i      (artry_n_i),
  .ts_launch_i    (ts_launch_i),
  .br_n_o         (br_n_o),
  .br_oe_o        (br_oe_o),
  .start_tenure_o (start_tenure_o),
  .outstanding_o  (outstanding_o)
);

// File: tb/addr_req_ctl_tb_top.sv
module addr_req_ctl_tb_top;

  localparam int unsigned MAXT = 5;
  localparam int unsigned CW   = $clog2(MAXT + 1);

  typedef struct {
    bit    br_n;
    bit    oe;
    bit    st;
    int    cnt;
    string tag;
  } exp_t;

  logic          clk;
  logic          rst_n;
  logic          checkstop_i;
  logic          txn_pend_i;
  logic          cancel_i;
  logic          snp_cpbk_i;
  logic          bg_n_i;
  logic          abb_n_i;
  logic          artry_n_i;
  logic          ts_launch_i;
  logic          tenure_done_i;
  logic          br_n_o;
  logic          br_oe_o;
  logic          start_tenure_o;
  logic [CW-1:0] outstanding_o;

  int   n_checks;
  int   n_errors;
  int   cycles;
  bit   done_flag;
  exp_t sb_q[$];

  addr_req_ctl #(.MAX_TENURES(MAXT)) dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .checkstop_i    (checkstop_i),
    .txn_pend_i     (txn_pend_i),
    .cancel_i       (cancel_i),
    .snp_cpbk_i     (snp_cpbk_i),
    .bg_n_i         (bg_n_i),
    .abb_n_i        (abb_n_i),
    .artry_n_i      (artry_n_i),
    .ts_launch_i    (ts_launch_i),
    .tenure_done_i  (tenure_done_i),
    .br_n_o         (br_n_o),
    .br_oe_o        (br_oe_o),
    .start_tenure_o (start_tenure_o),
    .outstanding_o  (outstanding_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check_bit(input string tag, input string what, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Driver: apply inputs for the next edge and queue the expected outputs after it
  task automatic step(input bit pend, input bit cancel, input bit cpbk, input bit bg_n,
                      input bit abb_n, input bit artry_n, input bit ts, input bit done,
                      input bit chk, input bit e_br, input bit e_oe, input bit e_st,
                      input int e_cnt, input string tag);
    exp_t e;
    @(negedge clk);
    txn_pend_i    = pend;
    cancel_i      = cancel;
    snp_cpbk_i    = cpbk;
    bg_n_i        = bg_n;
    abb_n_i       = abb_n;
    artry_n_i     = artry_n;
    ts_launch_i   = ts;
    tenure_done_i = done;
    checkstop_i   = chk;
    e.br_n = e_br;
    e.oe   = e_oe;
    e.st   = e_st;
    e.cnt  = e_cnt;
    e.tag  = tag;
    sb_q.push_back(e);
  endtask

  // Monitor: compare shortly after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check_bit(e.tag, "br_n_o", br_n_o, e.br_n);
        check_bit(e.tag, "br_oe_o", br_oe_o, e.oe);
        check_bit(e.tag, "start_tenure_o", start_tenure_o, e.st);
        n_checks++;
        if (int'(outstanding_o) != e.cnt) begin
          n_errors++;
          $display("FAIL %s outstanding_o actual=%0d expected=%0d", e.tag, outstanding_o, e.cnt);
        end
      end
    end
  end

  // Watchdog
  initial begin
    cycles = 0;
    while (!done_flag && cycles < 5000) begin
      @(posedge clk);
      cycles++;
    end
    if (!done_flag) begin
      n_errors++;
      $display("FAIL watchdog actual=%0d cycles expected=completion", cycles);
      $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    n_checks = 0;
    n_errors = 0;
    done_flag = 1'b0;
    rst_n = 1'b0;
    checkstop_i = 1'b0; txn_pend_i = 1'b0; cancel_i = 1'b0; snp_cpbk_i = 1'b0;
    bg_n_i = 1'b1; abb_n_i = 1'b1; artry_n_i = 1'b1; ts_launch_i = 1'b0;
    tenure_done_i = 1'b0;
    repeat (3) @(negedge clk);
    // R9: pin floats during hard reset, even with work pending
    txn_pend_i = 1'b1;
    @(negedge clk);
    check_bit("R9", "br_oe_o in reset", br_oe_o, 1'b0);
    check_bit("R9", "br_n_o in reset", br_n_o, 1'b1);
    txn_pend_i = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    // R10: still held one cycle after rst_n rises
    check_bit("R10", "br_oe_o before release", br_oe_o, 1'b0);
    @(negedge clk);

    //    pend can cpb bg  abb rty ts  dn  chk  br  oe  st  cnt
    step(0, 0, 0, 1, 1, 1, 0, 0, 0,  1, 1, 0, 0, "R10 idle after release");
    step(1, 0, 0, 1, 1, 1, 0, 0, 0,  0, 1, 0, 0, "R1 request");
    step(1, 0, 0, 1, 1, 1, 0, 0, 0,  0, 1, 0, 0, "R1 hold");
    step(1, 0, 0, 0, 1, 1, 0, 0, 0,  1, 1, 1, 0, "R7 qualified grant");
    step(1, 0, 0, 0, 0, 1, 1, 0, 0,  1, 1, 0, 1, "R3 launch drops request");
    step(1, 0, 0, 1, 0, 1, 0, 0, 0,  0, 1, 0, 1, "R1 more work");
    step(1, 0, 0, 1, 0, 0, 0, 0, 0,  1, 1, 0, 1, "R4 retry drop");
    step(1, 0, 0, 1, 0, 1, 0, 0, 0,  0, 1, 0, 1, "R4 resume");
    step(1, 0, 1, 1, 0, 0, 0, 0, 0,  0, 1, 0, 1, "R5 copyback keeps request");
    step(1, 1, 0, 1, 0, 1, 0, 0, 0,  1, 1, 0, 1, "R6 cancel");
    step(1, 1, 0, 0, 1, 1, 0, 0, 0,  1, 1, 0, 1, "R6 cancel blocks start");
    step(0, 0, 0, 0, 1, 1, 0, 0, 0,  1, 1, 0, 1, "R2 parked no work");
    step(1, 0, 0, 0, 1, 1, 0, 0, 0,  1, 1, 1, 1, "R2 parked start");
    step(1, 0, 0, 0, 1, 1, 0, 0, 0,  1, 1, 0, 1, "R7 no repeat pulse");
    step(1, 0, 0, 0, 1, 0, 0, 0, 0,  1, 1, 0, 1, "R7 retry disqualifies");
    step(1, 0, 0, 0, 0, 1, 0, 0, 0,  0, 1, 0, 1, "R2 grant but busy");
    step(1, 0, 0, 1, 0, 1, 1, 0, 0,  1, 1, 0, 2, "R8 inc");
    step(1, 0, 0, 1, 0, 1, 1, 0, 0,  1, 1, 0, 3, "R8 inc");
    step(1, 0, 0, 1, 0, 1, 1, 0, 0,  1, 1, 0, 4, "R8 inc");
    step(1, 0, 0, 1, 0, 1, 1, 0, 0,  1, 1, 0, 5, "R8 reach max");
    step(1, 0, 0, 1, 0, 1, 1, 0, 0,  1, 1, 0, 5, "R8 saturate high");
    step(1, 0, 0, 1, 0, 1, 0, 0, 0,  0, 1, 0, 5, "R8 request at max");
    step(1, 0, 0, 1, 0, 1, 0, 1, 0,  0, 1, 0, 4, "R8 dec");
    step(1, 0, 0, 1, 0, 1, 1, 1, 0,  1, 1, 0, 4, "R8 inc and dec");
    step(0, 0, 0, 1, 1, 1, 0, 1, 0,  1, 1, 0, 3, "R8 dec");
    step(0, 0, 0, 1, 1, 1, 0, 1, 0,  1, 1, 0, 2, "R8 dec");
    step(0, 0, 0, 1, 1, 1, 0, 1, 0,  1, 1, 0, 1, "R8 dec");
    step(0, 0, 0, 1, 1, 1, 0, 1, 0,  1, 1, 0, 0, "R8 dec");
    step(0, 0, 0, 1, 1, 1, 0, 1, 0,  1, 1, 0, 0, "R8 saturate low");
    step(1, 0, 0, 1, 1, 1, 0, 0, 1,  1, 0, 0, 0, "R9 checkstop floats");
    step(1, 0, 0, 1, 1, 1, 0, 0, 0,  0, 1, 0, 0, "R9 checkstop cleared");
    step(0, 0, 0, 1, 1, 1, 0, 0, 0,  1, 1, 0, 0, "R1 idle");

    repeat (3) @(posedge clk);
    #5;
    done_flag = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule